// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative TLB

This block is a small, fully associative translation cache whose entries each describe a page of one of several sizes. Every entry holds its own page-kind code. That code selects which upper bits of the virtual address the entry compares, so 1 MiB, 64 KiB, 4 KiB and 1 KiB mappings can sit side by side in the same array.

A lookup is purely combinational. It takes a 32-bit virtual address and, in the same cycle, returns a hit flag with the stored physical base, kind code, domain and permission bits of the matching entry. A fill port, driven by a table walker, writes a new entry into the slot named by a global round-robin pointer. The fill takes effect at the next clock edge.

Two maintenance inputs clear state. One clears the whole array. The other clears only the first entry that matches a given address. The entry count is a parameter.

Top module: `multi_size_tlb`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and the round-robin pointer is zero.
- R2: Kind codes map to compare masks as follows:
  - 1 (small) gives 0xFFFFF000.
  - 2 (large) gives 0xFFFF0000.
  - 3 (section) gives 0xFFF00000.
  - 4 (extended small) gives 0xFFFFF000.
  - 5 (tiny) gives 0xFFFFFC00.

  An entry hits when the lookup address ANDed with the entry's mask equals the stored virtual address ANDed with the same mask.
- R3: A fill stores both the virtual and the physical address ANDed with the mask of the new kind. A hit returns that masked physical base together with the kind, domain and permission values written by the fill. A miss drives zero on all four fields.
- R4: Entries with kind code 0 never hit. When several entries hit, the one with the lowest index is returned.
- R5: A fill writes the slot at the round-robin pointer, and the pointer then advances modulo the entry count. With 8 entries, the ninth fill therefore replaces the first.
- R6: Invalidate-all makes every entry invalid and returns the pointer to zero.
- R7: Invalidate-by-address clears only the lowest-indexed entry that matches the given address, and leaves the pointer unchanged.
- R8: A fill is not visible to a lookup in the same cycle. It becomes visible from the next cycle.
- R9: When either invalidate input is asserted in the same cycle as a fill, the invalidate is performed and the fill is dropped. The pointer does not advance, and invalidate-all takes precedence over invalidate-by-address.
- R10: Kind codes 0, 6 and 7 have a compare mask of zero. A fill with such a code still occupies its slot and advances the pointer, but the entry never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pbase | output | 32 | Masked physical base of the winning entry |
| lk_kind | output | 3 | Kind code of the winning entry |
| lk_domain | output | DOM_W | Domain of the winning entry |
| lk_perm | output | PERM_W | Permission bits of the winning entry |
| wr_en | input | 1 | Fill strobe |
| wr_vaddr | input | 32 | Fill virtual address |
| wr_pbase | input | 32 | Fill physical address |
| wr_kind | input | 3 | Fill kind code |
| wr_domain | input | DOM_W | Fill domain |
| wr_perm | input | PERM_W | Fill permission bits |
| inv_all | input | 1 | Invalidate every entry and reset the pointer |
| inv_addr_en | input | 1 | Invalidate the first entry matching inv_addr |
| inv_addr | input | 32 | Address for invalidate-by-address |

## Verification
The assertions assume that the control inputs are known at every clock edge once reset is released. They also assume that a hit's base carries no bits below its page mask, which holds only because fills are masked on entry. The stimulus changes inputs only on the falling edge and checks the combinational lookup before the rising edge. It issues simultaneous fill and invalidate requests only in dedicated cycles, where the priority rule decides the outcome. Overlapping mappings of different sizes and the unused kind codes are written deliberately so that priority and masking are both exercised.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W = 32;

    localparam logic [2:0] KIND_NONE    = 3'd0;
    localparam logic [2:0] KIND_SMALL   = 3'd1;
    localparam logic [2:0] KIND_LARGE   = 3'd2;
    localparam logic [2:0] KIND_SECTION = 3'd3;
    localparam logic [2:0] KIND_XSMALL  = 3'd4;
    localparam logic [2:0] KIND_TINY    = 3'd5;

    // Compare mask per kind code; unused codes keep nothing and never hit.
    function automatic logic [VA_W-1:0] kind_mask(input logic [2:0] k);
        case (k)
            KIND_SMALL:   kind_mask = 32'hFFFF_F000;
            KIND_LARGE:   kind_mask = 32'hFFFF_0000;
            KIND_SECTION: kind_mask = 32'hFFF0_0000;
            KIND_XSMALL:  kind_mask = 32'hFFFF_F000;
            KIND_TINY:    kind_mask = 32'hFFFF_FC00;
            default:      kind_mask = 32'h0000_0000;
        endcase
    endfunction
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic [VA_W-1:0]                 addr,
    input  logic [ENTRIES-1:0][VA_W-1:0]    va,
    input  logic [ENTRIES-1:0][2:0]         kind,
    output logic [ENTRIES-1:0]              hits
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VA_W-1:0] msk;
        assign msk     = kind_mask(kind[g]);
        assign hits[g] = (msk != '0) && ((addr & msk) == (va[g] & msk));
    end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] hits,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    logic [ENTRIES-1:0] below;
    assign below = (ENTRIES'(1) << idx) - ENTRIES'(1);

    always_comb begin
        if (found) begin
            AST_PICK_LOWEST: assert (hits[idx] && ((hits & below) == '0)); // R4
        end
    end
endmodule

// File: rtl/multi_size_tlb.sv
module multi_size_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int DOM_W   = 4,
    parameter int PERM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic [VA_W-1:0]   lk_pbase,
    output logic [2:0]        lk_kind,
    output logic [DOM_W-1:0]  lk_domain,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              wr_en,
    input  logic [VA_W-1:0]   wr_vaddr,
    input  logic [VA_W-1:0]   wr_pbase,
    input  logic [2:0]        wr_kind,
    input  logic [DOM_W-1:0]  wr_domain,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              inv_all,
    input  logic              inv_addr_en,
    input  logic [VA_W-1:0]   inv_addr
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0][VA_W-1:0]   va;
        logic [ENTRIES-1:0][VA_W-1:0]   pa;
        logic [ENTRIES-1:0][2:0]        kind;
        logic [ENTRIES-1:0][DOM_W-1:0]  dom;
        logic [ENTRIES-1:0][PERM_W-1:0] perm;
        logic [IDX_W-1:0]               ptr;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_hits_w, iv_hits_w;
    logic               lk_found_w, iv_found_w;
    logic [IDX_W-1:0]   lk_idx_w, iv_idx_w;

    tlb_cam_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .addr(lk_vaddr), .va(st_q.va), .kind(st_q.kind), .hits(lk_hits_w)
    );
    tlb_first_hit #(.ENTRIES(ENTRIES)) u_lk_pick (
        .hits(lk_hits_w), .found(lk_found_w), .idx(lk_idx_w)
    );
    tlb_cam_match #(.ENTRIES(ENTRIES)) u_iv_match (
        .addr(inv_addr), .va(st_q.va), .kind(st_q.kind), .hits(iv_hits_w)
    );
    tlb_first_hit #(.ENTRIES(ENTRIES)) u_iv_pick (
        .hits(iv_hits_w), .found(iv_found_w), .idx(iv_idx_w)
    );

    assign lk_hit    = lk_found_w;
    assign lk_pbase  = lk_found_w ? st_q.pa[lk_idx_w]   : '0;
    assign lk_kind   = lk_found_w ? st_q.kind[lk_idx_w] : KIND_NONE;
    assign lk_domain = lk_found_w ? st_q.dom[lk_idx_w]  : '0;
    assign lk_perm   = lk_found_w ? st_q.perm[lk_idx_w] : '0;

    logic [VA_W-1:0] fill_mask;
    assign fill_mask = kind_mask(wr_kind);

    always_comb begin
        st_d = st_q;
        if (inv_all) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.kind[i] = KIND_NONE;
            end
            st_d.ptr = '0;
        end else if (inv_addr_en) begin
            if (iv_found_w) begin
                st_d.kind[iv_idx_w] = KIND_NONE;
            end
        end else if (wr_en) begin
            st_d.va[st_q.ptr]   = wr_vaddr & fill_mask;
            st_d.pa[st_q.ptr]   = wr_pbase & fill_mask;
            st_d.kind[st_q.ptr] = wr_kind;
            st_d.dom[st_q.ptr]  = wr_domain;
            st_d.perm[st_q.ptr] = wr_perm;
            st_d.ptr            = (st_q.ptr == LAST) ? '0 : st_q.ptr + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= LAST); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inv_all && !inv_addr_en) |=>
        (st_q.ptr == (($past(st_q.ptr) == LAST) ? '0 : $past(st_q.ptr) + IDX_W'(1)))); // R5
    AST_INV_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (!lk_hit && st_q.ptr == '0)); // R6
    AST_INV_ADDR_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_addr_en && !inv_all) |=> $stable(st_q.ptr)); // R7
    AST_HIT_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (kind_mask(lk_kind) != '0)); // R10
    AST_BASE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((lk_pbase & ~kind_mask(lk_kind)) == '0)); // R3
endmodule

// File: tb/multi_size_tlb_test.sv
module multi_size_tlb_test;
    localparam int PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [31:0] lk_pbase;
    logic [2:0]  lk_kind;
    logic [3:0]  lk_domain;
    logic [11:0] lk_perm;
    logic        wr_en = 1'b0;
    logic [31:0] wr_vaddr = '0;
    logic [31:0] wr_pbase = '0;
    logic [2:0]  wr_kind = '0;
    logic [3:0]  wr_domain = '0;
    logic [11:0] wr_perm = '0;
    logic        inv_all = 1'b0;
    logic        inv_addr_en = 1'b0;
    logic [31:0] inv_addr = '0;

    multi_size_tlb #(.ENTRIES(N), .DOM_W(4), .PERM_W(12)) uut (.*);

    always #(PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference
    logic [31:0] m_va [N];
    logic [31:0] m_pa [N];
    int          m_kind [N];
    logic [3:0]  m_dom [N];
    logic [11:0] m_perm [N];
    int          m_ptr;

    function automatic logic [31:0] mmask(int k);
        if (k == 1 || k == 4) return 32'hFFFFF000;
        if (k == 2) return 32'hFFFF0000;
        if (k == 3) return 32'hFFF00000;
        if (k == 5) return 32'hFFFFFC00;
        return 32'h0;
    endfunction

    function automatic int mfind(logic [31:0] a);
        for (int i = 0; i < N; i++) begin
            if (mmask(m_kind[i]) != 0 && ((a & mmask(m_kind[i])) == (m_va[i] & mmask(m_kind[i]))))
                return i;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_va[i] = '0; m_pa[i] = '0; m_kind[i] = 0; m_dom[i] = '0; m_perm[i] = '0;
        end
        m_ptr = 0;
    endtask

    task automatic step(string tag);
        int e;
        logic [31:0] xp; logic [2:0] xk; logic [3:0] xd; logic [11:0] xr; logic xh;
        #1;
        e = mfind(lk_vaddr);
        xh = (e >= 0);
        xp = xh ? m_pa[e] : '0;
        xk = xh ? 3'(m_kind[e]) : '0;
        xd = xh ? m_dom[e] : '0;
        xr = xh ? m_perm[e] : '0;
        checks++;
        if (lk_hit !== xh || lk_pbase !== xp || lk_kind !== xk || lk_domain !== xd || lk_perm !== xr) begin
            errors++;
            $display("FAIL %s addr=%h got hit=%b pa=%h k=%0d d=%h p=%h exp hit=%b pa=%h k=%0d d=%h p=%h",
                     tag, lk_vaddr, lk_hit, lk_pbase, lk_kind, lk_domain, lk_perm, xh, xp, xk, xd, xr);
        end
        @(posedge clk);
        if (inv_all) begin
            for (int i = 0; i < N; i++) m_kind[i] = 0;
            m_ptr = 0;
        end else if (inv_addr_en) begin
            e = mfind(inv_addr);
            if (e >= 0) m_kind[e] = 0;
        end else if (wr_en) begin
            m_va[m_ptr] = wr_vaddr & mmask(int'(wr_kind));
            m_pa[m_ptr] = wr_pbase & mmask(int'(wr_kind));
            m_kind[m_ptr] = int'(wr_kind);
            m_dom[m_ptr] = wr_domain;
            m_perm[m_ptr] = wr_perm;
            m_ptr = (m_ptr + 1) % N;
        end
        @(negedge clk);
        wr_en = 0; inv_all = 0; inv_addr_en = 0;
    endtask

    task automatic look(logic [31:0] a, string tag);
        lk_vaddr = a;
        step(tag);
    endtask

    task automatic fill(logic [31:0] va, logic [31:0] pa, logic [2:0] k, logic [3:0] d,
                        logic [11:0] p, string tag);
        wr_en = 1; wr_vaddr = va; wr_pbase = pa; wr_kind = k; wr_domain = d; wr_perm = p;
        step(tag);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: empty after reset
        look(32'h0000_0000, "R1");
        look(32'h1234_5678, "R1");
        // R8: same-cycle fill not visible
        lk_vaddr = 32'h1234_5678;
        fill(32'h1234_5678, 32'hABCD_EF12, 3'd3, 4'h5, 12'hC0C, "R8");
        look(32'h1234_5678, "R8");
        // R2 / R3: each page size
        look(32'h123F_FFFF, "R2");
        look(32'h1240_0000, "R2");
        fill(32'h2000_1ABC, 32'h0111_1FFF, 3'd1, 4'h1, 12'h3F0, "R3");
        fill(32'h3002_5000, 32'h0222_FFFF, 3'd2, 4'h2, 12'h0F0, "R3");
        fill(32'h4000_3000, 32'h0333_3333, 3'd4, 4'h3, 12'h030, "R3");
        fill(32'h5000_0C00, 32'h0444_4FFF, 3'd5, 4'h4, 12'h010, "R3");
        look(32'h2000_1000, "R3");
        look(32'h2000_2000, "R2");
        look(32'h3002_FFFF, "R3");
        look(32'h3003_0000, "R2");
        look(32'h4000_3FFF, "R3");
        look(32'h5000_0FFF, "R3");
        look(32'h5000_0BFF, "R2");
        // R4: overlap, lowest index wins
        fill(32'h1234_5000, 32'h7777_7000, 3'd1, 4'h9, 12'hFF0, "R4");
        look(32'h1234_5010, "R4");
        // R10: unused code never hits
        fill(32'h6000_0000, 32'h6000_0000, 3'd6, 4'h6, 12'h111, "R10");
        look(32'h6000_0000, "R10");
        look(32'h0000_0000, "R10");
        // R7: invalidate first match only
        inv_addr_en = 1; inv_addr = 32'h1234_5010; lk_vaddr = 32'h1234_5010;
        step("R7");
        look(32'h1234_5010, "R7");
        look(32'h1230_0000, "R7");
        // R5: pointer kept by R7, wraps modulo N
        fill(32'h7000_0000, 32'h0700_0000, 3'd3, 4'h7, 12'hC00, "R5");
        fill(32'h8000_0000, 32'h0800_0000, 3'd3, 4'h8, 12'hC00, "R5");
        look(32'h8000_0000, "R5");
        look(32'h2000_1000, "R5");
        fill(32'h9000_0000, 32'h0900_0000, 3'd3, 4'hA, 12'hC00, "R5");
        look(32'h2000_1000, "R5");
        look(32'h9000_0000, "R5");
        // R9: invalidate-by-address beats fill
        inv_addr_en = 1; inv_addr = 32'h3002_5000;
        wr_en = 1; wr_vaddr = 32'hC000_0000; wr_pbase = 32'h0C00_0000; wr_kind = 3'd3;
        step("R9");
        look(32'h3002_5000, "R9");
        look(32'hC000_0000, "R9");
        // R9 / R6: invalidate-all beats fill
        inv_all = 1; inv_addr_en = 1; inv_addr = 32'h4000_3000;
        wr_en = 1; wr_vaddr = 32'hA000_0000; wr_pbase = 32'h0A00_0000; wr_kind = 3'd3;
        step("R9");
        look(32'hA000_0000, "R9");
        look(32'h5000_0C00, "R6");
        look(32'h9000_0000, "R6");
        // R6: pointer back to zero, ninth fill evicts first
        for (int i = 0; i < N + 1; i++)
            fill({4'hB, 4'(i), 24'h0}, {4'h0, 4'(i), 24'h0}, 3'd3, 4'(i), 12'(i), "R6");
        look(32'hB000_0000, "R6");
        look(32'hB100_0000, "R6");
        look(32'hB800_0000, "R6");
        // R1: reset clears everything
        rst_n = 0;
        @(posedge clk); model_reset(); @(negedge clk);
        rst_n = 1;
        look(32'hB100_0000, "R1");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule